// File: doc/BRIEF.md
# Stream Cipher Key Tester

This block tries candidate keys against a known stretch of keystream from a byte-permutation stream cipher with a 40-bit key. For each candidate it runs the 256-step key schedule on a 256-byte permutation. It then produces as many keystream bytes as there are reference bytes and compares each one with its reference. When every byte matches, the block stops and reports the key. When any byte differs, it moves on to the next candidate. Candidates form an arithmetic sequence: a starting key, then that key plus one stride, plus two strides, and so on. Several copies of the block, given different starting offsets and a common stride, can therefore split a key space among themselves.

Both permutations live in one two-port 512-byte RAM. The address MSB selects the half. While one half is scrambled for the current key, the idle port writes the identity permutation into the other half, ready for the next key. Each candidate therefore costs exactly three cycles per loop step, with no extra setup time. Only the very first candidate needs a separate 256-cycle fill.

Top module: `keysearch_core`

## Requirements
- R1: After reset, found and busy are low and cur_key is zero.
- R2: A start pulse while the block is idle or holding a hit begins a new run: busy rises on the next cycle. While busy is high, start, key_base, key_step and ref_bytes are ignored, and the run continues unchanged.
- R3: The m-th key tested (m counted from 0) is (key_base + m × key_step) mod 2^KEY_W, with both inputs sampled at start. cur_key shows each key from the moment its schedule begins.
- R4: The schedule adds key byte (i mod KEY_BYTES) in step i. Key byte b is bits [8b+7:8b] of the key.
- R5: Keystream byte k (k counted from 0) is compared with ref_bytes[8k+7:8k] as sampled at start, for k from 0 to N_REF-1.
- R6: A key is reported only when all N_REF bytes match. A mismatch in any byte, including the last one, makes the block go on to the next key.
- R7: One key takes exactly (256 + N_REF) × 3 cycles, after a single 256-cycle fill per run. found rises at clock edge 256 + (m+1)(768 + 3·N_REF) + 2, counting the edge that sampled start as edge 0.
- R8: On a hit, found goes high and busy goes low. cur_key then holds the matching key, and both stay unchanged until the next start.
- R9: Every key after the first uses the RAM half that was filled during the previous key's schedule, and gives the same result as a key tested from a fresh fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when the block is not busy |
| key_base | input | KEY_W | First candidate key |
| key_step | input | KEY_W | Stride between candidate keys |
| ref_bytes | input | 8·N_REF | Expected keystream, byte k in bits [8k+7:8k] |
| found | output | 1 | High while holding a matching key |
| busy | output | 1 | High while the fill or key testing runs |
| cur_key | output | KEY_W | Key under test, or the matching key after a hit |

## Verification
A wrong entry in the working permutation, whether from a bad swap, a wrong index or a wrong key byte, changes the keystream. It shows up at the ports as a missed hit, or as a hit on the wrong key, at the decision edge of the key being tested, about 780 cycles after that key starts. An error in the background identity fill does not affect the first key at all and only appears on the second one, so the hit trials place the target at key positions 0, 1 and 2. Errors in timing or decision order move the edge where found rises, and that edge is checked to the exact cycle.

// File: rtl/keysearch_core.sv
module keysearch_core #(
  parameter int N_REF     = 4,
  parameter int KEY_BYTES = 5,
  localparam int KEY_W    = 8 * KEY_BYTES,
  localparam int CW       = $clog2(N_REF + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [KEY_W-1:0]   key_base,
  input  logic [KEY_W-1:0]   key_step,
  input  logic [8*N_REF-1:0] ref_bytes,
  output logic               found,
  output logic               busy,
  output logic [KEY_W-1:0]   cur_key
);

  typedef enum logic [2:0] {ST_IDLE, ST_FILL, ST_SCHED, ST_STREAM, ST_HIT} st_t;

  st_t               st;
  logic [1:0]        ph;
  logic [7:0]        ix, jx, sv, tx;
  logic              hf, pend, mism;
  logic [CW-1:0]     kc, ci;
  logic [KEY_W-1:0]  cand, krot, step_r;
  logic [8*N_REF-1:0] ref_q;

  logic [8:0] ad_a, ad_b;
  logic       we_a, we_b;
  logic [7:0] wd_a, wd_b, rd_a, rd_b;
  logic [7:0] mem [512];

  wire [7:0] kbyte    = (st == ST_SCHED) ? krot[7:0] : 8'd0;
  wire [7:0] j_nx     = jx + rd_a + kbyte;
  wire [7:0] ref_b    = ref_q[int'(ci)*8 +: 8];
  wire       in_loop  = (st == ST_SCHED) || (st == ST_STREAM);
  wire       cmp_now  = pend && in_loop && (ph == 2'd1);
  wire       byte_ok  = (rd_b == ref_b);
  wire       last_cmp = (ci == CW'(N_REF - 1));
  wire       last_ks  = (kc == CW'(N_REF - 1));
  wire [KEY_W-1:0] nxt_key = cand + step_r;

  assign found   = (st == ST_HIT);
  assign busy    = (st == ST_FILL) || in_loop;
  assign cur_key = cand;

  always_ff @(posedge clk) begin
    if (we_a) mem[ad_a] <= wd_a;
    if (we_b) mem[ad_b] <= wd_b;
    rd_a <= mem[ad_a];
    rd_b <= mem[ad_b];
  end

  always_comb begin
    ad_a = {hf, ix};
    ad_b = {hf, tx};
    we_a = 1'b0;
    we_b = 1'b0;
    wd_a = rd_a;
    wd_b = sv;
    case (st)
      ST_FILL: begin
        ad_b = {1'b0, ix};
        we_b = 1'b1;
        wd_b = ix;
      end
      ST_SCHED, ST_STREAM: begin
        case (ph)
          2'd0: begin
            ad_a = {hf, ix};
            ad_b = (st == ST_SCHED) ? {~hf, tx} : {hf, tx};
          end
          2'd1: begin
            ad_a = {hf, j_nx};
            if (st == ST_SCHED) begin
              ad_b = {~hf, ix};
              we_b = 1'b1;
              wd_b = ix;
            end
          end
          default: begin
            ad_a = {hf, ix};
            we_a = 1'b1;
            wd_a = rd_a;
            ad_b = {hf, jx};
            we_b = 1'b1;
            wd_b = sv;
          end
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      ph     <= 2'd0;
      ix     <= 8'd0;
      jx     <= 8'd0;
      sv     <= 8'd0;
      tx     <= 8'd0;
      hf     <= 1'b0;
      pend   <= 1'b0;
      mism   <= 1'b0;
      kc     <= '0;
      ci     <= '0;
      cand   <= '0;
      krot   <= '0;
      step_r <= '0;
      ref_q  <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_HIT: begin
          if (start) begin
            st     <= ST_FILL;
            ix     <= 8'd0;
            hf     <= 1'b0;
            ph     <= 2'd0;
            pend   <= 1'b0;
            mism   <= 1'b0;
            ci     <= '0;
            cand   <= key_base;
            krot   <= key_base;
            step_r <= key_step;
            ref_q  <= ref_bytes;
          end
        end
        ST_FILL: begin
          ix <= ix + 8'd1;
          if (ix == 8'hff) begin
            st <= ST_SCHED;
            jx <= 8'd0;
            ph <= 2'd0;
          end
        end
        ST_SCHED, ST_STREAM: begin
          case (ph)
            2'd0: ph <= 2'd1;
            2'd1: begin
              sv <= rd_a;
              jx <= j_nx;
              ph <= 2'd2;
            end
            default: begin
              ph <= 2'd0;
              ix <= ix + 8'd1;
              if (st == ST_SCHED) begin
                krot <= {krot[7:0], krot[KEY_W-1:8]};
                if (ix == 8'hff) begin
                  st <= ST_STREAM;
                  ix <= 8'd1;
                  jx <= 8'd0;
                  kc <= '0;
                end
              end else begin
                tx   <= sv + rd_a;
                pend <= 1'b1;
                kc   <= kc + 1'b1;
                if (last_ks) begin
                  st   <= ST_SCHED;
                  hf   <= ~hf;
                  ix   <= 8'd0;
                  jx   <= 8'd0;
                  kc   <= '0;
                  cand <= nxt_key;
                  krot <= nxt_key;
                end
              end
            end
          endcase
          if (cmp_now) begin
            pend <= 1'b0;
            if (last_cmp) begin
              ci   <= '0;
              mism <= 1'b0;
              if (!mism && byte_ok) begin
                st   <= ST_HIT;
                cand <= cand - step_r;
              end
            end else begin
              ci   <= ci + 1'b1;
              mism <= mism | ~byte_ok;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/keysearch_core_chk.sv
module keysearch_core_chk #(
  parameter int N_REF = 4,
  parameter int KEY_W = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             found,
  input logic             busy,
  input logic [KEY_W-1:0] cur_key,
  input logic [KEY_W-1:0] stp
);

  localparam int PER = 768 + 3 * N_REF;

  logic [31:0]      cnt;
  logic             first;
  logic [KEY_W-1:0] key_d;
  logic             busy_d;

  wire key_moved = busy && busy_d && (cur_key != key_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= 32'd0;
      first  <= 1'b1;
      key_d  <= '0;
      busy_d <= 1'b0;
    end else begin
      key_d  <= cur_key;
      busy_d <= busy;
      if (!busy) begin
        cnt   <= 32'd0;
        first <= 1'b1;
      end else if (key_moved) begin
        cnt   <= 32'd1;
        first <= 1'b0;
      end else begin
        cnt <= cnt + 32'd1;
      end
    end
  end

  p_found_busy_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(found && busy));

  p_hit_hold_r8: assert property (@(posedge clk) disable iff (rst)
    found && !start |=> found && $stable(cur_key));

  p_run_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    busy |=> busy || found);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !busy && !found && !start |=> !busy && !found);

  p_hit_from_run_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(found) |-> $past(busy));

  p_key_advance_r3: assert property (@(posedge clk) disable iff (rst)
    key_moved |-> cur_key == key_d + stp);

  p_key_period_r7: assert property (@(posedge clk) disable iff (rst)
    key_moved |-> cnt == (first ? 32'(256 + PER) : 32'(PER)));

endmodule

bind keysearch_core keysearch_core_chk #(.N_REF(N_REF), .KEY_W(KEY_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .found(found), .busy(busy),
  .cur_key(cur_key), .stp(step_r)
);

// File: tb/tb_keysearch_core.sv
module tb_keysearch_core;
  localparam int NR  = 4;
  localparam int KB  = 5;
  localparam int KW  = 8 * KB;
  localparam int PER = 768 + 3 * NR;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [KW-1:0] key_base = '0;
  logic [KW-1:0] key_step = '0;
  logic [8*NR-1:0] ref_bytes = '0;
  logic          found, busy;
  logic [KW-1:0] cur_key;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  keysearch_core #(.N_REF(NR), .KEY_BYTES(KB)) dut (
    .clk(clk), .rst(rst), .start(start), .key_base(key_base),
    .key_step(key_step), .ref_bytes(ref_bytes),
    .found(found), .busy(busy), .cur_key(cur_key)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h, expected %0h", req, act, exp);
    end
  endtask

  // Independent model of R4 (schedule, key byte i mod 5) and R5 (byte k at [8k+7:8k])
  function automatic logic [8*NR-1:0] model_stream(input logic [KW-1:0] k);
    logic [7:0] s [256];
    logic [7:0] i, j, t;
    logic [8*NR-1:0] o;
    for (int a = 0; a < 256; a++) s[a] = 8'(a);
    j = 8'd0;
    for (int a = 0; a < 256; a++) begin
      j = j + s[a] + k[(a % KB)*8 +: 8];
      t = s[a]; s[a] = s[j]; s[j] = t;
    end
    i = 8'd0; j = 8'd0; o = '0;
    for (int b = 0; b < NR; b++) begin
      i = i + 8'd1;
      j = j + s[i];
      t = s[i]; s[i] = s[j]; s[j] = t;
      o[b*8 +: 8] = s[8'(s[i] + s[j])];
    end
    return o;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_trial(input logic [KW-1:0] base, input logic [KW-1:0] stp,
                           input logic [8*NR-1:0] rv, input int maxk, input bit poke);
    int hit_m = -1;
    int cnt;
    int limit;
    logic [KW-1:0] hk = '0;
    for (int m = 0; m < maxk; m++) begin
      if (hit_m < 0 && model_stream(KW'(base + KW'(m) * stp)) == rv) begin
        hit_m = m;
        hk = KW'(base + KW'(m) * stp);
      end
    end
    limit = 256 + (maxk + 1) * PER + 10;
    @(negedge clk);
    key_base = base; key_step = stp; ref_bytes = rv; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (cnt < limit && !found) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      start = 1'b0;
      if (cnt == 10) check(busy && !found, "R2 run begins", {found, busy}, 2'b01);
      if (cnt == 300) check(cur_key == base, "R3 first key shown", cur_key, base);
      if (cnt == 256 + PER + 50 && (hit_m < 0 || hit_m >= 1))
        check(cur_key == KW'(base + stp), "R3 second key shown", cur_key, KW'(base + stp));
      if (poke && cnt == 1000) begin
        start = 1'b1; key_base = ~base; key_step = stp + 1; ref_bytes = ~rv;
      end
    end
    if (hit_m >= 0) begin
      // R7: exact hit edge; R6/R9: right key at position hit_m
      check(found, "R6 hit reported", found, 1);
      check(cnt == 256 + (hit_m + 1) * PER + 2, "R7 hit timing", cnt, 256 + (hit_m + 1) * PER + 2);
      check(cur_key == hk, "R9 matching key", cur_key, hk);
      check(!busy, "R8 busy low on hit", busy, 0);
      repeat (20) @(negedge clk);
      check(found && cur_key == hk, "R8 hit held", cur_key, hk);
    end else begin
      check(!found && busy, "R6 no false hit", {found, busy}, 2'b01);
      do_reset();
    end
  endtask

  initial begin
    logic [KW-1:0] b, s;
    logic [8*NR-1:0] rv;
    int m;
    void'($urandom(32'd20240611));
    do_reset();
    // R1 reset state
    check(!found, "R1 found low", found, 0);
    check(!busy, "R1 busy low", busy, 0);
    check(cur_key == '0, "R1 key zero", cur_key, 0);

    // R4/R5 hit on first key
    b = 40'h01_0203_0405;
    run_trial(b, 40'd96, model_stream(b), 2, 1'b0);
    // R2/R9 restart from hit, third key, start poked mid-run
    run_trial(40'd5, 40'd96, model_stream(40'd5 + 40'd192), 3, 1'b1);
    // R3 wrap modulo 2^40
    b = 40'hFF_FFFF_FFF0;
    run_trial(b, 40'd96, model_stream(40'd80), 3, 1'b0);
    // R6 only the last byte differs
    rv = model_stream(40'd7) ^ ({8'h01, {(8*NR-8){1'b0}}});
    run_trial(40'd7, 40'd96, rv, 2, 1'b0);
    // R6 only the first byte differs
    rv = model_stream(40'd9) ^ (8*NR)'(8'h80);
    run_trial(40'd9, 40'd96, rv, 2, 1'b0);

    for (int t = 0; t < 5; t++) begin
      b = {8'($urandom), $urandom};
      s = {8'($urandom), $urandom} | 40'd1;
      m = int'($urandom % 3);
      run_trial(b, s, model_stream(KW'(b + KW'(m) * s)), 3, t[0]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule